// File: doc/BRIEF.md
# Register-Pair Command Packet Decoder

This block sits on a 32-bit command stream and pulls register writes out of the pair-style command packets it carries. Every other packet is consumed by its stated length without side effects, and one-dword padding words are discarded. For each register named in a pair packet, the decoder places one offset/value write on a valid/ready output port. The write is tagged with the register space it belongs to: context, shader or user-config.

Two body layouts are handled. In the plain layout each register takes an offset dword followed by a value dword. In the packed layout a register-count dword comes first, then groups of three dwords: one dword holding two 16-bit offsets (low half first), then the two values. The decoder checks every packet against its rules. When a rule is broken it sets a sticky error flag with a cause code, and it drops whatever is left of that packet's body. A single output slot back-pressures the input, so no dword is taken while a decoded write is still waiting.

Top module: `regpair_pkt_decoder`

## Requirements
- R1: After reset, wr_valid, err_flag and err_cause are all 0 and in_ready is 1.
- R2: Header bits 31:30 give the packet type. A type-2 dword with bits 29:0 all zero, a type-3 header with opcode 0x10 and count 0x3FFF (header only), and any type-3 packet whose opcode is not a pair opcode are consumed without writes or errors. The last case uses header bits 29:16 as count and consumes count+1 body dwords.
- R3: A type-0 or type-1 header, or a type-2 dword with any of bits 29:0 set, raises cause 6.
- R4: Opcodes 0xB8 (space 0), 0xBA (space 1) and 0xBE (space 2) carry (offset, value) dword pairs. Each pair yields one write whose offset is bits 15:0 of the offset dword. Space codes: 0 context, 1 shader, 2 user-config.
- R5: Opcodes 0xB9 (space 0), 0xBB and 0xBD (space 1) carry a register-count dword and then 3-dword groups. Each group yields the write (bits 15:0, first value) and then the write (bits 31:16, second value).
- R6: For opcode 0xBD a register count above 14 raises cause 2. A count of exactly 14 is accepted, and the other packed opcodes have no such limit.
- R7: An odd register count in a packed packet raises cause 1. This check comes before the limit and length checks.
- R8: An offset equal to the offset directly before it in the same packet raises cause 3. This applies inside one packed dword and across groups or pairs. Writes already issued stand, and the rest of the body is dropped.
- R9: A pair opcode whose header bit 2 is 0 raises cause 4, and its whole body is dropped.
- R10: While wr_valid is 1 and wr_ready is 0, in_ready is 0 and wr_offset, wr_value and wr_space hold steady.
- R11: A packed body length (count+1) other than 1+3*(register count/2) raises cause 5 at the count dword. An odd body length on a plain pair opcode raises cause 5 at the header. In both cases the rest of the body is dropped.
- R12: err_flag stays set and err_cause keeps the first cause until an err_clear pulse. An error in the same cycle as err_clear is recorded.
- R13: A write reaches the port in the cycle after the dword that completes it is accepted. Errors show on err_flag/err_cause in the cycle after the offending dword is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command dword present |
| in_ready | output | 1 | Decoder takes the dword this cycle |
| in_data | input | 32 | Command dword |
| wr_valid | output | 1 | Register write present |
| wr_ready | input | 1 | Consumer takes the write |
| wr_offset | output | 16 | Register offset |
| wr_value | output | 32 | Register value |
| wr_space | output | 2 | Register space (0 context, 1 shader, 2 user-config) |
| err_clear | input | 1 | Clears the sticky error |
| err_flag | output | 1 | Sticky error flag |
| err_cause | output | 3 | First error cause (1 odd count, 2 over limit, 3 equal offsets, 4 no filter bit, 5 length, 6 bad type) |

## Verification
There is exactly one register between an accepted dword and its effect. A write therefore becomes visible one cycle after the value dword that completes it is taken, and an error one cycle after the offending dword. The bench annotates every stimulus dword with its expected effect when it builds a packet. It applies that effect to its model at the accepting clock edge and compares the ports at the following falling edge. On every cycle it also checks that wr_valid is 1 exactly when the model holds a pending write. This pins each write to its cycle under random input gaps and random output back-pressure.

// File: rtl/rpd_pkg.sv
package rpd_pkg;

    localparam int DW       = 32;
    localparam int OFFW     = 16;
    localparam int CNTW     = 14;
    localparam int BLW      = CNTW + 1;
    localparam int CAUSEW   = 3;
    localparam int PACKED_N_LIMIT = 14;

    localparam logic [7:0] OP_NOP           = 8'h10;
    localparam logic [7:0] OP_CTX_PAIRS     = 8'hB8;
    localparam logic [7:0] OP_CTX_PACKED    = 8'hB9;
    localparam logic [7:0] OP_SH_PAIRS      = 8'hBA;
    localparam logic [7:0] OP_SH_PACKED     = 8'hBB;
    localparam logic [7:0] OP_SH_PACKED_LIM = 8'hBD;
    localparam logic [7:0] OP_UC_PAIRS      = 8'hBE;

    typedef enum logic [1:0] {
        SPC_CTX  = 2'd0,
        SPC_SH   = 2'd1,
        SPC_UCFG = 2'd2
    } spc_e;

    typedef enum logic [CAUSEW-1:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_ODD    = 3'd1,
        CAUSE_OVER   = 3'd2,
        CAUSE_DUP    = 3'd3,
        CAUSE_NOFILT = 3'd4,
        CAUSE_LEN    = 3'd5,
        CAUSE_TYPE   = 3'd6
    } cause_e;

    typedef enum logic [2:0] {
        HK_PAD,
        HK_BADTYPE,
        HK_HDRONLY,
        HK_SKIP,
        HK_PACKED,
        HK_UNPACKED
    } hkind_e;

    typedef struct packed {
        hkind_e           kind;
        spc_e             spc;
        logic             limited;
        logic             filt;
        logic [BLW-1:0]   blen;
    } hdr_t;

    typedef struct packed {
        logic [OFFW-1:0]  off;
        logic [DW-1:0]    val;
        spc_e             spc;
    } wr_t;

    function automatic spc_e op_space(input logic [7:0] op);
        if (op == OP_CTX_PAIRS || op == OP_CTX_PACKED) return SPC_CTX;
        if (op == OP_UC_PAIRS) return SPC_UCFG;
        return SPC_SH;
    endfunction

    function automatic logic op_is_packed(input logic [7:0] op);
        return (op == OP_CTX_PACKED) || (op == OP_SH_PACKED) || (op == OP_SH_PACKED_LIM);
    endfunction

    function automatic logic op_is_plain(input logic [7:0] op);
        return (op == OP_CTX_PAIRS) || (op == OP_SH_PAIRS) || (op == OP_UC_PAIRS);
    endfunction

endpackage

// File: rtl/rpd_hdr_decode.sv
module rpd_hdr_decode
    import rpd_pkg::*;
(
    input  logic [DW-1:0] dw,
    output hdr_t          hdr
);
    logic [1:0]      ptype;
    logic [CNTW-1:0] cnt;
    logic [7:0]      op;
    logic            hdr_flags_unused;

    assign ptype = dw[31:30];
    assign cnt   = dw[29:16];
    assign op    = dw[15:8];
    assign hdr_flags_unused = ^dw[1:0];

    always_comb begin
        hdr         = '0;
        hdr.blen    = {1'b0, cnt} + BLW'(1);
        hdr.filt    = dw[2];
        hdr.spc     = op_space(op);
        hdr.limited = (op == OP_SH_PACKED_LIM);
        unique case (ptype)
            2'b10: hdr.kind = (dw[29:0] == '0) ? HK_PAD : HK_BADTYPE;
            2'b11: begin
                if (op == OP_NOP && cnt == '1)
                    hdr.kind = HK_HDRONLY;
                else if (op_is_packed(op))
                    hdr.kind = HK_PACKED;
                else if (op_is_plain(op))
                    hdr.kind = HK_UNPACKED;
                else
                    hdr.kind = HK_SKIP;
            end
            default: hdr.kind = HK_BADTYPE;
        endcase
    end
endmodule

// File: rtl/rpd_wr_slot.sv
module rpd_wr_slot
    import rpd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  wr_t  din,
    input  logic ready,
    output logic valid,
    output wr_t  dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            dout  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            dout  <= din;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/rpd_err_sticky.sv
module rpd_err_sticky
    import rpd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              set,
    input  cause_e            code,
    output logic              flag,
    output logic [CAUSEW-1:0] cause
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            cause <= '0;
        end else if (clr) begin
            flag  <= set;
            cause <= set ? code : CAUSE_NONE;
        end else if (set && !flag) begin
            flag  <= 1'b1;
            cause <= code;
        end
    end
endmodule

// File: rtl/regpair_pkt_decoder.sv
module regpair_pkt_decoder
    import rpd_pkg::*;
#(
    parameter int LIMIT_N = PACKED_N_LIMIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DW-1:0]     in_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [OFFW-1:0]   wr_offset,
    output logic [DW-1:0]     wr_value,
    output logic [1:0]        wr_space,
    input  logic              err_clear,
    output logic              err_flag,
    output logic [CAUSEW-1:0] err_cause
);
    typedef enum logic [2:0] {
        ST_HDR, ST_SKIP, ST_PCNT, ST_POFF, ST_PV0, ST_PV1, ST_UOFF, ST_UVAL
    } st_e;

    st_e             st_q, st_d;
    logic [BLW-1:0]  rem_q, rem_d;
    spc_e            spc_q, spc_d;
    logic            lim_q, lim_d;
    logic [OFFW-1:0] off0_q, off0_d, off1_q, off1_d, prev_q, prev_d;
    logic            pv_q, pv_d;

    hdr_t   hdr;
    logic   acc;
    logic   err_set;
    cause_e err_code;
    logic   ld;
    wr_t    ld_wr;
    wr_t    slot_q;

    logic [33:0]     need_len;
    logic            last;
    logic [OFFW-1:0] lo_off, hi_off;

    rpd_hdr_decode u_hdr (
        .dw  (in_data),
        .hdr (hdr)
    );

    assign in_ready = !wr_valid || wr_ready;
    assign acc      = in_valid && in_ready;
    assign need_len = 34'd1 + 34'd3 * {3'b000, in_data[31:1]};
    assign last     = (rem_q == BLW'(1));
    assign lo_off   = in_data[OFFW-1:0];
    assign hi_off   = in_data[DW-1:OFFW];

    always_comb begin
        st_d     = st_q;
        rem_d    = rem_q;
        spc_d    = spc_q;
        lim_d    = lim_q;
        off0_d   = off0_q;
        off1_d   = off1_q;
        prev_d   = prev_q;
        pv_d     = pv_q;
        err_set  = 1'b0;
        err_code = CAUSE_NONE;
        ld       = 1'b0;
        ld_wr    = '{off: off0_q, val: in_data, spc: spc_q};
        if (acc) begin
            if (st_q != ST_HDR) rem_d = rem_q - BLW'(1);
            unique case (st_q)
                ST_HDR: begin
                    rem_d = hdr.blen;
                    spc_d = hdr.spc;
                    lim_d = hdr.limited;
                    pv_d  = 1'b0;
                    unique case (hdr.kind)
                        HK_PAD, HK_HDRONLY: st_d = ST_HDR;
                        HK_BADTYPE: begin
                            err_set  = 1'b1;
                            err_code = CAUSE_TYPE;
                        end
                        HK_SKIP: st_d = ST_SKIP;
                        HK_PACKED: begin
                            if (!hdr.filt) begin
                                err_set  = 1'b1;
                                err_code = CAUSE_NOFILT;
                                st_d     = ST_SKIP;
                            end else begin
                                st_d = ST_PCNT;
                            end
                        end
                        default: begin
                            if (!hdr.filt) begin
                                err_set  = 1'b1;
                                err_code = CAUSE_NOFILT;
                                st_d     = ST_SKIP;
                            end else if (hdr.blen[0]) begin
                                err_set  = 1'b1;
                                err_code = CAUSE_LEN;
                                st_d     = ST_SKIP;
                            end else begin
                                st_d = ST_UOFF;
                            end
                        end
                    endcase
                end
                ST_SKIP: st_d = ST_SKIP;
                ST_PCNT: begin
                    st_d = ST_POFF;
                    if (in_data[0]) begin
                        err_set  = 1'b1;
                        err_code = CAUSE_ODD;
                    end else if (lim_q && in_data > DW'(LIMIT_N)) begin
                        err_set  = 1'b1;
                        err_code = CAUSE_OVER;
                    end else if (need_len != {19'd0, rem_q}) begin
                        err_set  = 1'b1;
                        err_code = CAUSE_LEN;
                    end
                    if (err_set) st_d = ST_SKIP;
                end
                ST_POFF: begin
                    off0_d = lo_off;
                    off1_d = hi_off;
                    prev_d = hi_off;
                    pv_d   = 1'b1;
                    if ((pv_q && lo_off == prev_q) || lo_off == hi_off) begin
                        err_set  = 1'b1;
                        err_code = CAUSE_DUP;
                        st_d     = ST_SKIP;
                    end else begin
                        st_d = ST_PV0;
                    end
                end
                ST_PV0: begin
                    ld   = 1'b1;
                    st_d = ST_PV1;
                end
                ST_PV1: begin
                    ld    = 1'b1;
                    ld_wr = '{off: off1_q, val: in_data, spc: spc_q};
                    st_d  = ST_POFF;
                end
                ST_UOFF: begin
                    off0_d = lo_off;
                    prev_d = lo_off;
                    pv_d   = 1'b1;
                    if (pv_q && lo_off == prev_q) begin
                        err_set  = 1'b1;
                        err_code = CAUSE_DUP;
                        st_d     = ST_SKIP;
                    end else begin
                        st_d = ST_UVAL;
                    end
                end
                default: begin
                    ld   = 1'b1;
                    st_d = ST_UOFF;
                end
            endcase
            if (st_q != ST_HDR && last) st_d = ST_HDR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_HDR;
            rem_q  <= '0;
            spc_q  <= SPC_CTX;
            lim_q  <= 1'b0;
            off0_q <= '0;
            off1_q <= '0;
            prev_q <= '0;
            pv_q   <= 1'b0;
        end else begin
            st_q   <= st_d;
            rem_q  <= rem_d;
            spc_q  <= spc_d;
            lim_q  <= lim_d;
            off0_q <= off0_d;
            off1_q <= off1_d;
            prev_q <= prev_d;
            pv_q   <= pv_d;
        end
    end

    rpd_wr_slot u_slot (
        .clk   (clk),
        .rst   (rst),
        .load  (ld),
        .din   (ld_wr),
        .ready (wr_ready),
        .valid (wr_valid),
        .dout  (slot_q)
    );

    assign wr_offset = slot_q.off;
    assign wr_value  = slot_q.val;
    assign wr_space  = slot_q.spc;

    rpd_err_sticky u_err (
        .clk   (clk),
        .rst   (rst),
        .clr   (err_clear),
        .set   (err_set),
        .code  (err_code),
        .flag  (err_flag),
        .cause (err_cause)
    );
endmodule

// File: rtl/rpd_checker.sv
module rpd_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [15:0] wr_offset,
    input logic [31:0] wr_value,
    input logic [1:0]  wr_space,
    input logic        err_clear,
    input logic        err_flag,
    input logic [2:0]  err_cause
);
    // R10
    stall_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |-> !in_ready);

    // R10
    stall_holds_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_offset)
                                     && $stable(wr_value) && $stable(wr_space)));

    // R12
    sticky_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !err_clear) |=> (err_flag && $stable(err_cause)));

    // R12
    flag_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> (err_cause != 3'd0 && err_cause <= 3'd6));

    // R13
    write_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_valid) |-> $past(in_valid && in_ready));

    // R13
    refill_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> (!wr_valid || $past(in_valid && in_ready)));
endmodule

bind regpair_pkt_decoder rpd_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_offset (wr_offset),
    .wr_value  (wr_value),
    .wr_space  (wr_space),
    .err_clear (err_clear),
    .err_flag  (err_flag),
    .err_cause (err_cause)
);

// File: tb/regpair_pkt_decoder_tb.sv
module regpair_pkt_decoder_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [15:0] wr_offset;
    logic [31:0] wr_value;
    logic [1:0]  wr_space;
    logic        err_clear = 1'b0;
    logic        err_flag;
    logic [2:0]  err_cause;

    always #(CLK_PERIOD/2) clk = ~clk;

    regpair_pkt_decoder dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_offset(wr_offset), .wr_value(wr_value),
        .wr_space(wr_space), .err_clear(err_clear), .err_flag(err_flag), .err_cause(err_cause)
    );

    typedef struct {
        logic [31:0] d;
        bit          dv;
        bit          clr;
        bit          hw;
        logic [15:0] off;
        logic [31:0] val;
        logic [1:0]  sp;
        logic [2:0]  err;
    } ent_t;

    ent_t stim[$];
    ent_t expw[$];
    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit m_flag = 0;
    logic [2:0] m_cause = 3'd0;
    bit bp_on = 0;
    bit gap_on = 0;
    bit done = 0;
    logic [15:0] po[0:31];
    logic [31:0] pv[0:31];

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] d, input bit hw, input logic [15:0] off,
                       input logic [31:0] val, input logic [1:0] sp, input logic [2:0] err);
        ent_t e;
        e.d = d; e.dv = 1; e.clr = 0; e.hw = hw; e.off = off; e.val = val; e.sp = sp; e.err = err;
        stim.push_back(e);
    endtask

    task automatic put_clr(input bit with_dw, input logic [31:0] d, input logic [2:0] err);
        ent_t e;
        e.d = d; e.dv = with_dw; e.clr = 1; e.hw = 0; e.off = '0; e.val = '0; e.sp = '0; e.err = err;
        stim.push_back(e);
    endtask

    function automatic logic [1:0] sp_of(input logic [7:0] op);
        if (op == 8'hB8 || op == 8'hB9) return 2'd0;
        if (op == 8'hBE) return 2'd2;
        return 2'd1;
    endfunction

    function automatic logic [31:0] hdr3(input logic [7:0] op, input int blen, input bit filt);
        return {2'b11, 14'(blen - 1), op, 5'b0, filt, 2'b10};
    endfunction

    // Packed pair packet: header, count dword, 3-dword groups from po/pv.
    task automatic pk(input logic [7:0] op, input int rc, input int blen, input bit filt);
        bit dead;
        logic [2:0] e;
        dead = !filt;
        put(hdr3(op, blen, filt), 0, 0, 0, 0, filt ? 3'd0 : 3'd4);
        e = 0;
        if (!dead) begin
            if (rc % 2 != 0) e = 3'd1;
            else if (op == 8'hBD && rc > 14) e = 3'd2;
            else if (blen != 1 + 3 * (rc / 2)) e = 3'd5;
            if (e != 0) dead = 1;
        end
        put(32'(rc), 0, 0, 0, 0, e);
        for (int i = 0; i < blen - 1; i++) begin
            int g = i / 3;
            int k = i % 3;
            e = 0;
            if (k == 0) begin
                if (!dead && ((g > 0 && po[2*g] == po[2*g-1]) || po[2*g] == po[2*g+1])) begin
                    e = 3'd3; dead = 1;
                end
                put({po[2*g+1], po[2*g]}, 0, 0, 0, 0, e);
            end else if (k == 1) begin
                put(pv[2*g], !dead, po[2*g], pv[2*g], sp_of(op), 0);
            end else begin
                put(pv[2*g+1], !dead, po[2*g+1], pv[2*g+1], sp_of(op), 0);
            end
        end
    endtask

    // Plain pair packet: header, (offset, value) dwords from po/pv.
    task automatic up(input logic [7:0] op, input int blen, input bit filt);
        bit dead;
        logic [2:0] e;
        e = !filt ? 3'd4 : ((blen % 2 != 0) ? 3'd5 : 3'd0);
        dead = (e != 0);
        put(hdr3(op, blen, filt), 0, 0, 0, 0, e);
        for (int i = 0; i < blen; i++) begin
            int p = i / 2;
            e = 0;
            if (i % 2 == 0) begin
                if (!dead && p > 0 && po[p] == po[p-1]) begin
                    e = 3'd3; dead = 1;
                end
                put({po[p] ^ 16'h5A5A, po[p]}, 0, 0, 0, 0, e);
            end else begin
                put(pv[p], !dead, po[p], pv[p], sp_of(op), 0);
            end
        end
    endtask

    task automatic fill(input int base);
        for (int i = 0; i < 32; i++) begin
            po[i] = 16'(base + 3 * i);
            pv[i] = 32'hC0DE_0000 + 32'(base * 64 + i);
        end
    endtask

    task automatic cycle();
        bit acc, pop_out, drv_clr;
        @(negedge clk);
        chk(err_flag == m_flag, "err_flag", err_flag, m_flag);
        chk(err_cause == m_cause, "err_cause", err_cause, m_cause);
        chk(wr_valid == (expw.size() != 0), "wr_valid timing", wr_valid, expw.size() != 0);
        if (wr_valid && expw.size() != 0) begin
            chk(wr_offset == expw[0].off, "wr_offset", wr_offset, expw[0].off);
            chk(wr_value == expw[0].val, "wr_value", wr_value, expw[0].val);
            chk(wr_space == expw[0].sp, "wr_space", wr_space, expw[0].sp);
        end
        wr_ready  = bp_on ? ($urandom % 3 != 0) : 1'b1;
        err_clear = 1'b0;
        in_valid  = 1'b0;
        drv_clr   = 0;
        if (stim.size() != 0) begin
            drv_clr   = stim[0].clr;
            err_clear = stim[0].clr;
            in_data   = stim[0].d;
            in_valid  = stim[0].dv && (!gap_on || ($urandom % 4 != 0));
        end
        #1;
        if (wr_valid && !wr_ready) chk(!in_ready, "in_ready under stall (R10)", in_ready, 0);
        acc     = in_valid && in_ready;
        pop_out = wr_valid && wr_ready;
        @(posedge clk);
        if (pop_out && expw.size() != 0) void'(expw.pop_front());
        if (drv_clr) begin
            ent_t h = stim[0];
            m_flag = 0;
            m_cause = 0;
            h.clr = 0;
            stim[0] = h;
            if (!h.dv) void'(stim.pop_front());
        end
        if (acc) begin
            ent_t e = stim.pop_front();
            if (e.err != 0 && !m_flag) begin
                m_flag = 1;
                m_cause = e.err;
            end
            if (e.hw) expw.push_back(e);
        end
    endtask

    task automatic run();
        while (stim.size() != 0 || expw.size() != 0) cycle();
        repeat (2) cycle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        cur_req = "R1";
        chk(wr_valid == 0, "wr_valid after reset", wr_valid, 0);
        chk(err_flag == 0, "err_flag after reset", err_flag, 0);
        chk(err_cause == 0, "err_cause after reset", err_cause, 0);
        chk(in_ready == 1, "in_ready after reset", in_ready, 1);

        // R2: padding, header-only NOP, other opcodes skipped by length
        cur_req = "R2";
        put(32'h8000_0000, 0, 0, 0, 0, 0);
        put({2'b11, 14'h3FFF, 8'h10, 8'h00}, 0, 0, 0, 0, 0);
        put({2'b11, 14'd2, 8'h69, 8'h00}, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) put(32'hBB00_0000 + 32'(i), 0, 0, 0, 0, 0);
        put({2'b11, 14'd1, 8'h10, 8'h00}, 0, 0, 0, 0, 0);
        put({2'b11, 14'h0000, 8'hB8, 8'h00}, 0, 0, 0, 0, 0);
        put(32'h8000_0000, 0, 0, 0, 0, 0);
        fill(16'h100);
        up(8'hB8, 2, 1);
        run();

        // R3: bad packet types
        cur_req = "R3";
        put(32'h0000_1234, 0, 0, 0, 0, 3'd6);
        put_clr(0, 0, 0);
        put(32'h4000_0000, 0, 0, 0, 0, 3'd6);
        put_clr(0, 0, 0);
        put(32'h8000_0001, 0, 0, 0, 0, 3'd6);
        put_clr(0, 0, 0);
        run();

        // R4 R10 R13: plain pairs in three spaces under gaps and back-pressure
        cur_req = "R4";
        bp_on = 1; gap_on = 1;
        fill(16'h200); up(8'hB8, 6, 1);
        fill(16'h300); up(8'hBA, 4, 1);
        fill(16'h400); up(8'hBE, 2, 1);
        run();
        cur_req = "R10";
        fill(16'h500); up(8'hBA, 8, 1);
        run();

        // R5: packed pairs
        cur_req = "R5";
        fill(16'h600); pk(8'hB9, 4, 7, 1);
        fill(16'h700); pk(8'hBB, 2, 4, 1);
        pk(8'hBB, 0, 1, 1);
        run();
        bp_on = 0; gap_on = 0;

        // R6: limited variant boundary
        cur_req = "R6";
        fill(16'h800); pk(8'hBD, 14, 22, 1);
        pk(8'hBD, 16, 25, 1);
        put_clr(0, 0, 0);
        fill(16'h900); pk(8'hBB, 16, 25, 1);
        run();

        // R7: odd register count, stream realigns afterwards
        cur_req = "R7";
        fill(16'hA00); pk(8'hBB, 3, 4, 1);
        up(8'hBA, 2, 1);
        put_clr(0, 0, 0);
        run();

        // R8: equal adjacent offsets
        cur_req = "R8";
        fill(16'hB00); po[1] = po[0]; pk(8'hB9, 2, 4, 1);
        put_clr(0, 0, 0);
        fill(16'hB40); po[2] = po[1]; pk(8'hBB, 4, 7, 1);
        put_clr(0, 0, 0);
        fill(16'hB80); po[1] = po[0]; up(8'hB8, 4, 1);
        put_clr(0, 0, 0);
        fill(16'hBC0); po[2] = po[0]; up(8'hBE, 6, 1);
        run();

        // R9: reset-filter bit missing
        cur_req = "R9";
        fill(16'hC00); up(8'hB8, 4, 0);
        put_clr(0, 0, 0);
        pk(8'hBB, 2, 4, 0);
        put_clr(0, 0, 0);
        run();

        // R11: length mismatch
        cur_req = "R11";
        fill(16'hD00); pk(8'hBB, 2, 6, 1);
        put_clr(0, 0, 0);
        up(8'hBA, 3, 1);
        put_clr(0, 0, 0);
        pk(8'hB9, 4, 4, 1);
        put_clr(0, 0, 0);
        run();

        // R12: first cause kept, clear with simultaneous error
        cur_req = "R12";
        put(32'h0000_0000, 0, 0, 0, 0, 3'd6);
        fill(16'hE00); pk(8'hBB, 3, 4, 1);
        put_clr(1, 32'h4000_0000, 3'd6);
        put_clr(0, 0, 0);
        fill(16'hE40); pk(8'hBD, 2, 4, 1);
        run();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog timeout actual=%0h expected=%0h", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule